// File: doc/BRIEF.md
# Priority-Based Clock Reference Selector

This block picks which of fourteen clock reference inputs drives a downstream DPLL. Software programs a 4-bit priority for each input through a simple write port. The alarm logic supplies a 4-bit alarm word for each input. From these two sources the block decides every cycle which inputs are usable. It ranks the usable inputs and reports the three best as source identifiers.

A registered selection follows one of two policies. In revertive mode it always tracks the best usable input. In non-revertive mode it stays on the current input for as long as that input remains usable. A force field can override both policies and pin the selection to one input number.

All outputs are registered. A change on the alarm, force or mode inputs appears on the outputs one clock edge after it is sampled. A priority write takes effect at the edge that performs it, so its effect reaches the outputs at the following edge.

Top module: `ref_source_selector`

## Requirements
- R1: Each input's priority register resets to 0 and is loaded from `cfg_prio_i` at a clock edge where `cfg_we_i` is high and `cfg_idx_i` names that input (1 to 14). A write with `cfg_idx_i` equal to 0 or 15 changes no priority.
- R2: Input n (1 to 14) sets `valid_o[n-1]` when both of these hold: its priority is nonzero, and bits 0 (phase lock alarm), 1 (no-activity alarm) and 2 (hard frequency alarm) of its alarm word `alarm_i[4(n-1)+3 : 4(n-1)]` are all clear. Bit 3 (soft frequency alarm) has no effect on validity.
- R3: `rank1_o` is the identifier of the valid input with the numerically lowest priority value. A lower value means a higher priority. When priorities are equal, the lower input number wins. Identifier 0 means no input is valid.
- R4: `rank2_o` and `rank3_o` give the second and third entries in the same ordering, with no identifier repeated. Each is 0 when fewer valid inputs exist than its rank requires.
- R5: A `force_sel_i` value from 1 to 14 makes `sel_o` equal that value after the next edge, whether or not that input is valid.
- R6: A `force_sel_i` value of 0 or 15 leaves the selection to the automatic policy.
- R7: In automatic revertive mode (`revertive_i` = 1), `sel_o` equals `rank1_o`.
- R8: In automatic non-revertive mode (`revertive_i` = 0), `sel_o` keeps its value while that input stays valid, even if a better input becomes valid.
- R9: In automatic non-revertive mode, when the current selection is 0 or no longer valid, `sel_o` moves to `rank1_o`.
- R10: During and right after reset, `sel_o`, all three rank outputs and `valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Priority write strobe |
| cfg_idx_i | input | 4 | Input number to write, 1 to 14 |
| cfg_prio_i | input | 4 | Priority value to write, 0 excludes the input |
| alarm_i | input | 56 | Alarm words, 4 bits per input, input 1 in the lowest bits |
| force_sel_i | input | 4 | Forced input number, 0 or 15 selects automatic mode |
| revertive_i | input | 1 | 1 selects revertive mode, 0 selects non-revertive mode |
| sel_o | output | 4 | Selected input number, 0 means none |
| rank1_o | output | 4 | Best valid input |
| rank2_o | output | 4 | Second-best valid input |
| rank3_o | output | 4 | Third-best valid input |
| valid_o | output | 14 | Per-input valid bitmap |

## Verification
The assertions check several properties on every cycle. Identifiers stay in range. Ranks never repeat and never skip a position. Every reported rank points at a set valid bit. A revertive automatic cycle leaves the selection equal to the top rank. A forced value reaches the selection one edge later, and a stable valid selection does not move in non-revertive mode. The bench scenarios are needed for the exact ordering: tie-breaking by input number, ignoring soft alarms, dropping out-of-range writes, and the history-dependent sequence in which non-revertive mode holds a source, falls back, and then holds again after the better source recovers.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  localparam int unsigned ALM_W = 4;
  // alarm bits that disqualify an input: phase lock, no activity, hard freq
  localparam logic [ALM_W-1:0] ALM_BLOCK_MASK = 4'b0111;
endpackage

// File: rtl/ref_prio_regs.sv
module ref_prio_regs #(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ID_W    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ID_W-1:0]            idx_i,
  input  logic [PRIO_W-1:0]          prio_i,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    logic [PRIO_W-1:0] prio_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   prio_q <= '0;
      else if (we_i && idx_i == ID_W'(g + 1))        prio_q <= prio_i;
    end
    assign prio_o[g*PRIO_W +: PRIO_W] = prio_q;
  end

  p_bad_idx_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (idx_i == '0 || idx_i > ID_W'(NUM_SRC))) |=> $stable(prio_o));
endmodule

// File: rtl/ref_valid_gen.sv
module ref_valid_gen
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [NUM_SRC*ALM_W-1:0]  alarm_i,
  output logic [NUM_SRC-1:0]        valid_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign valid_o[g] = (|prio_i[g*PRIO_W +: PRIO_W]) &&
                        !(|(alarm_i[g*ALM_W +: ALM_W] & ALM_BLOCK_MASK));
  end
endmodule

// File: rtl/ref_min_pick.sv
module ref_min_pick #(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ID_W    = 4
) (
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]           id_o
);
  logic              found;
  logic [PRIO_W-1:0] best_prio;

  // strict compare keeps the lower index on ties
  always_comb begin
    found     = 1'b0;
    best_prio = '0;
    id_o      = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < best_prio)) begin
        found     = 1'b1;
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
        id_o      = ID_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/ref_rank3.sv
module ref_rank3 #(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ID_W    = 4,
  parameter int unsigned RANKS   = 3
) (
  input  logic [NUM_SRC-1:0]        valid_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic [RANKS*ID_W-1:0]     rank_o
);
  logic [NUM_SRC-1:0] mask [RANKS];
  logic [ID_W-1:0]    id   [RANKS];

  assign mask[0] = valid_i;

  for (genvar k = 0; k < RANKS; k++) begin : g_stage
    ref_min_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
      .cand_i (mask[k]),
      .prio_i (prio_i),
      .id_o   (id[k])
    );
    assign rank_o[k*ID_W +: ID_W] = id[k];
    if (k + 1 < RANKS) begin : g_next
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        assign mask[k+1][i] = mask[k][i] && (id[k] != ID_W'(i + 1));
      end
    end
  end
endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl #(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned ID_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ID_W-1:0]    force_i,
  input  logic               revertive_i,
  input  logic [NUM_SRC-1:0] valid_i,
  input  logic [ID_W-1:0]    best_i,
  output logic [ID_W-1:0]    sel_o
);
  logic [ID_W-1:0] sel_q, sel_d;
  logic            force_auto, cur_ok;

  assign force_auto = (force_i == '0) || (force_i > ID_W'(NUM_SRC));

  always_comb begin
    cur_ok = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel_q == ID_W'(i + 1)) cur_ok = valid_i[i];
  end

  always_comb begin
    if (!force_auto)                     sel_d = force_i;
    else if (revertive_i || !cur_ok)     sel_d = best_i;
    else                                 sel_d = sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  p_force_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i != '0 && force_i <= ID_W'(NUM_SRC)) |=> sel_o == $past(force_i));
  p_nonrev_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_auto && !revertive_i && sel_o != '0 && cur_ok) |=> $stable(sel_o));
endmodule

// File: rtl/ref_source_selector.sv
module ref_source_selector
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ID_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [ID_W-1:0]           cfg_idx_i,
  input  logic [PRIO_W-1:0]         cfg_prio_i,
  input  logic [NUM_SRC*ALM_W-1:0]  alarm_i,
  input  logic [ID_W-1:0]           force_sel_i,
  input  logic                      revertive_i,
  output logic [ID_W-1:0]           sel_o,
  output logic [ID_W-1:0]           rank1_o,
  output logic [ID_W-1:0]           rank2_o,
  output logic [ID_W-1:0]           rank3_o,
  output logic [NUM_SRC-1:0]        valid_o
);
  localparam int unsigned RANKS = 3;

  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0]        valid_now, valid_q;
  logic [RANKS*ID_W-1:0]     rank_d, rank_q;

  ref_prio_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .prio_i (cfg_prio_i),
    .prio_o (prio)
  );

  ref_valid_gen #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_valid (
    .prio_i  (prio),
    .alarm_i (alarm_i),
    .valid_o (valid_now)
  );

  ref_rank3 #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W), .RANKS(RANKS)) u_rank (
    .valid_i (valid_now),
    .prio_i  (prio),
    .rank_o  (rank_d)
  );

  ref_sel_ctrl #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_i     (force_sel_i),
    .revertive_i (revertive_i),
    .valid_i     (valid_now),
    .best_i      (rank_d[ID_W-1:0]),
    .sel_o       (sel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rank_q  <= '0;
    end else begin
      valid_q <= valid_now;
      rank_q  <= rank_d;
    end
  end

  assign valid_o = valid_q;
  assign rank1_o = rank_q[0*ID_W +: ID_W];
  assign rank2_o = rank_q[1*ID_W +: ID_W];
  assign rank3_o = rank_q[2*ID_W +: ID_W];

  // rank identifiers must point at set valid bits
  logic r1_hit, r2_hit, r3_hit;
  always_comb begin
    r1_hit = 1'b0; r2_hit = 1'b0; r3_hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rank1_o == ID_W'(i + 1)) r1_hit = valid_o[i];
      if (rank2_o == ID_W'(i + 1)) r2_hit = valid_o[i];
      if (rank3_o == ID_W'(i + 1)) r3_hit = valid_o[i];
    end
  end

  p_id_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o <= ID_W'(NUM_SRC) && rank1_o <= ID_W'(NUM_SRC) &&
    rank2_o <= ID_W'(NUM_SRC) && rank3_o <= ID_W'(NUM_SRC));
  p_rank_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rank1_o == '0 || r1_hit) && (rank2_o == '0 || r2_hit) && (rank3_o == '0 || r3_hit));
  p_rank_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rank2_o == '0 || rank1_o != '0) && (rank3_o == '0 || rank2_o != '0));
  p_rank_distinct_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rank2_o == '0 || rank2_o != rank1_o) &&
    (rank3_o == '0 || (rank3_o != rank1_o && rank3_o != rank2_o)));
  p_rev_tracks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (revertive_i && (force_sel_i == '0 || force_sel_i > ID_W'(NUM_SRC)))
    |=> sel_o == rank1_o);
  p_reset_clear_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (sel_o == '0 && rank_q == '0 && valid_o == '0));
endmodule

// File: tb/ref_source_selector_tb.sv
module ref_source_selector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 14;
  localparam int WD = 20000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [3:0]    cfg_prio = '0;
  logic [N*4-1:0] alarm = '0;
  logic [3:0]    force_sel = '0;
  logic          revertive = 1'b1;
  logic [3:0]    sel, r1, r2, r3;
  logic [N-1:0]  valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_source_selector u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .cfg_we_i (cfg_we), .cfg_idx_i (cfg_idx),
    .cfg_prio_i (cfg_prio), .alarm_i (alarm), .force_sel_i (force_sel),
    .revertive_i (revertive), .sel_o (sel), .rank1_o (r1), .rank2_o (r2),
    .rank3_o (r3), .valid_o (valid)
  );

  typedef struct {
    string        tag;
    logic [3:0]   sel, r1, r2, r3;
    logic [N-1:0] valid;
  } exp_t;

  exp_t q[$];
  event mon_ev;
  int   n_vec = 0, n_bad = 0;
  bit   done = 0;

  int   prio_m [N];
  logic [3:0] sel_m = '0;

  function automatic logic [N-1:0] model_valid();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (prio_m[i] != 0) && (alarm[i*4 +: 3] == 3'b000);
    return v;
  endfunction

  function automatic logic [3:0] model_pick(logic [N-1:0] cand);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (cand[i] && (best < 0 || prio_m[i] < prio_m[best])) best = i;
    return (best < 0) ? 4'd0 : 4'(best + 1);
  endfunction

  task automatic write_prio(input int idx, input int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_prio = 4'(p);
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx >= 1 && idx <= N) prio_m[idx-1] = p;
  endtask

  task automatic set_alarm(input int src, input logic [3:0] a);
    @(negedge clk);
    alarm[(src-1)*4 +: 4] = a;
  endtask

  // driver: wait for the design to settle, push the expected item, wake monitor
  task automatic check(input string tag);
    exp_t e;
    logic [N-1:0] v, m;
    repeat (2) @(posedge clk);
    @(negedge clk);
    v = model_valid();
    e.tag = tag; e.valid = v;
    m = v;
    e.r1 = model_pick(m); if (e.r1 != 0) m[e.r1-1] = 1'b0;
    e.r2 = model_pick(m); if (e.r2 != 0) m[e.r2-1] = 1'b0;
    e.r3 = model_pick(m);
    if (force_sel >= 1 && force_sel <= N) sel_m = force_sel;
    else if (revertive)                   sel_m = e.r1;
    else if (!(sel_m != 0 && v[sel_m-1])) sel_m = e.r1;
    e.sel = sel_m;
    q.push_back(e);
    ->mon_ev;
    #1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(mon_ev);
      e = q.pop_front();
      n_vec++;
      if (sel !== e.sel || r1 !== e.r1 || r2 !== e.r2 || r3 !== e.r3 || valid !== e.valid) begin
        n_bad++;
        $display("FAIL %s: act sel=%0d r=%0d/%0d/%0d valid=%b exp sel=%0d r=%0d/%0d/%0d valid=%b",
                 e.tag, sel, r1, r2, r3, valid, e.sel, e.r1, e.r2, e.r3, e.valid);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    repeat (3) @(negedge clk);
    // R10: reset state visible while reset is held
    n_vec++;
    if (sel !== 0 || r1 !== 0 || r2 !== 0 || r3 !== 0 || valid !== 0) begin
      n_bad++;
      $display("FAIL R10 reset: act sel=%0d r1=%0d valid=%b exp all 0", sel, r1, valid);
    end
    rst_ni = 1'b1;
    check("R10 after reset");

    // R1 R3: tie between inputs 2 and 3, input 5 excluded by priority 0
    write_prio(1, 5);  write_prio(2, 3);  write_prio(3, 3);
    write_prio(4, 9);  write_prio(5, 0);  write_prio(6, 12);
    write_prio(7, 7);  write_prio(9, 15); write_prio(14, 1);
    check("R1 R2 R3 R4 R7 initial ranking");
    // R3: lower index wins a tie once 14 drops out via no-activity
    set_alarm(14, 4'b0010);
    check("R3 tie and R7 revert");
    // R2: soft alarm alone keeps input 2 valid
    set_alarm(2, 4'b1000);
    check("R2 soft alarm ignored");
    // R2: hard and phase alarms drop it
    set_alarm(2, 4'b0100);
    check("R2 hard alarm");
    set_alarm(3, 4'b0001);
    check("R2 R4 phase alarm shifts ranks");
    // R1: writes to index 0 and 15 must not land
    write_prio(0, 1);
    write_prio(15, 1);
    check("R1 out-of-range writes ignored");
    // R4: fewer than three valid
    for (int i = 4; i <= 14; i++) set_alarm(i, 4'b0010);
    check("R4 one valid input");
    set_alarm(1, 4'b0100);
    check("R4 none valid");
    // restore
    for (int i = 1; i <= 14; i++) set_alarm(i, 4'b0000);
    check("R7 restore");
    // R5: forcing an excluded input
    @(negedge clk); force_sel = 4'd5;
    check("R5 force invalid input");
    @(negedge clk); force_sel = 4'd9;
    check("R5 force low priority input");
    // R6: 15 is automatic
    @(negedge clk); force_sel = 4'd15;
    check("R6 force 15 automatic");
    // R8 R9: non-revertive sequence
    @(negedge clk); force_sel = 4'd0; revertive = 1'b0;
    set_alarm(14, 4'b0001);
    check("R6 R9 non-revertive picks best");
    set_alarm(14, 4'b0000);
    check("R8 better input returns, keep current");
    set_alarm(2, 4'b0010);
    check("R9 current fails, move to best");
    set_alarm(2, 4'b0000);
    check("R8 hold after recovery");
    // release from force in non-revertive keeps forced input while valid
    @(negedge clk); force_sel = 4'd7;
    check("R5 force in non-revertive");
    @(negedge clk); force_sel = 4'd0;
    check("R8 release keeps forced valid input");
    @(negedge clk); revertive = 1'b1;
    check("R7 back to revertive");

    done = 1;
    summary();
    $finish;
  end
endmodule